// File: doc/BRIEF.md
# Game Switch State Transfer Sequencer

This block swaps the running game for another one. A request names the target game. The block does not act until the frame being drawn has finished. It then asks the CPU to stop and waits for the CPU to acknowledge. Once halted, the CPU has placed its register snapshot in the low words of working memory, so the block saves that whole working region to persistent storage, in the slot that belongs to the game being left.

Each transfer is followed by a verify pass. The verify pass re-reads every destination word and compares the 32-bit modular sum with the sum taken while the source was read. It can also re-read the source and compare each word against its copy. After a good save, the working region is filled with zeros. The target game's image is then copied from storage into working memory and verified the same way. Finally the CPU is released and the active game number is updated.

Any mismatch parks the block in an error state. In that state the CPU stays halted and an error flag is raised until reset.

Top module: `game_swap_seq`

## Requirements
- R1: After reset, busy, cpu_halt and sw_error are 0, cur_game equals the INIT_GAME parameter (0 by default), and neither mem_req nor st_req is asserted.
- R2: A request (req_valid high while busy is low) is accepted at a clock edge. busy is high from the next cycle until the release cycle has passed, then returns to 0.
- R3: cpu_halt stays low until frame_done is seen after the request was accepted. It rises in the cycle after the edge that samples frame_done.
- R4: No memory or storage access takes place while cpu_halted is low.
- R5: The save copies working-memory word i to the storage address {game, i}. Here game is cur_game in the upper GW bits and i is in the lower AW bits.
- R6: After a good save, every working-memory word is written with zero exactly once, before any word of the new image is written.
- R7: The load copies storage word {target, i} to memory word i. On success, cur_game becomes the target, cpu_halt drops and busy drops. A target equal to cur_game leaves the memory image unchanged.
- R8: After each copy, the 32-bit modular sum of the source words is compared with the sum of the destination words re-read. If they differ, sw_error goes high and stays high until reset, with cpu_halt and busy held high, no further port accesses, and later requests ignored.
- R9: With ECHO=1, each destination word is also compared with a fresh read of its source word. A word mismatch causes the error of R8 even when the two sums agree.
- R10: A request that arrives while busy is high has no effect on the target or on the outcome.
- R11: A port request (mem_req or st_req) keeps its address, write enable and write data stable until its ready is seen. At most one of the two ports is requested in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request strobe |
| req_game | input | GW | Target game number |
| frame_done | input | 1 | End-of-frame pulse from the renderer |
| cpu_halted | input | 1 | CPU acknowledges that it has stopped |
| busy | output | 1 | A switch is in progress (or in error) |
| cpu_halt | output | 1 | Halt request to the CPU |
| sw_error | output | 1 | Transfer check failed |
| cur_game | output | GW | Game currently active |
| mem_req | output | 1 | Working-memory access request |
| mem_we | output | 1 | Working-memory write (1) or read (0) |
| mem_addr | output | AW | Working-memory word index |
| mem_wdata | output | DW | Working-memory write data |
| mem_ready | input | 1 | Working-memory access completes this cycle |
| mem_rdata | input | DW | Working-memory read data, valid with mem_ready |
| st_req | output | 1 | Storage access request |
| st_we | output | 1 | Storage write (1) or read (0) |
| st_addr | output | GW+AW | Storage address {game, word index} |
| st_wdata | output | DW | Storage write data |
| st_ready | input | 1 | Storage access completes this cycle |
| st_rdata | input | DW | Storage read data, valid with st_ready |

## Verification
busy is due one edge after an accepted request. cpu_halt is due one edge after frame_done is sampled, and port traffic starts only when the modelled CPU's delayed acknowledge arrives. Every copied word costs two handshakes and every verified word one or two, so the length of a switch depends on the stall pattern. For that reason the bench never counts cycles for completion. A monitor waits at falling edges for busy to drop or sw_error to rise, then compares memory, storage and outputs against expectations that the driver queued before the request. The timed checks (busy, cpu_halt, the idle window before frame_done) are sampled at the falling edge right after the edge that should change them.

// File: rtl/game_swap_seq.sv
module game_swap_seq #(
  parameter int DW        = 16,
  parameter int WORDS     = 16,
  parameter int GAMES     = 4,
  parameter int INIT_GAME = 0,
  parameter int ECHO      = 1,
  localparam int AW  = $clog2(WORDS),
  localparam int GW  = $clog2(GAMES),
  localparam int SAW = GW + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [GW-1:0]  req_game,
  input  logic           frame_done,
  input  logic           cpu_halted,
  output logic           busy,
  output logic           cpu_halt,
  output logic           sw_error,
  output logic [GW-1:0]  cur_game,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  output logic           st_req,
  output logic           st_we,
  output logic [SAW-1:0] st_addr,
  output logic [DW-1:0]  st_wdata,
  input  logic           st_ready,
  input  logic [DW-1:0]  st_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_FRAME, S_HALT, S_SAVE, S_CLEAR, S_LOAD, S_VERIFY, S_RESUME, S_ERROR
  } state_t;

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  state_t        state;
  logic [GW-1:0] cur, tgt;
  logic [AW-1:0] idx;
  logic          sub, ld, mis;
  logic [DW-1:0] hold;
  logic [31:0]   src_sum, dst_sum;

  wire in_save = state == S_SAVE;
  wire in_clr  = state == S_CLEAR;
  wire in_load = state == S_LOAD;
  wire in_vfy  = state == S_VERIFY;
  wire last    = idx == LAST;

  assign mem_req   = (in_save && !sub) || in_clr || (in_load && sub) || (in_vfy && (ld ? !sub : sub));
  assign mem_we    = in_clr || (in_load && sub);
  assign mem_addr  = idx;
  assign mem_wdata = in_clr ? '0 : hold;

  assign st_req   = (in_save && sub) || (in_load && !sub) || (in_vfy && (ld ? sub : !sub));
  assign st_we    = in_save && sub;
  assign st_addr  = {(in_save || (in_vfy && !ld)) ? cur : tgt, idx};
  assign st_wdata = hold;

  wire mem_done = mem_req && mem_ready;
  wire st_done  = st_req && st_ready;

  wire [DW-1:0] drd      = ld ? mem_rdata : st_rdata;
  wire [DW-1:0] srd      = ld ? st_rdata : mem_rdata;
  wire          vdone    = in_vfy && (mem_done || st_done);
  wire          word_end = vdone && (sub || ECHO == 0);
  wire [31:0]   fin_dst  = dst_sum + (sub ? 32'd0 : 32'(drd));
  wire          fin_mis  = mis || (sub && srd != hold);
  wire          pass     = (fin_dst == src_sum) && !fin_mis;

  assign busy     = state != S_IDLE;
  assign sw_error = state == S_ERROR;
  assign cpu_halt = state inside {S_HALT, S_SAVE, S_CLEAR, S_LOAD, S_VERIFY, S_ERROR};
  assign cur_game = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= GW'(INIT_GAME);
      tgt     <= '0;
      idx     <= '0;
      sub     <= 1'b0;
      ld      <= 1'b0;
      mis     <= 1'b0;
      hold    <= '0;
      src_sum <= '0;
      dst_sum <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          tgt   <= req_game;
          state <= S_WAIT_FRAME;
        end
        S_WAIT_FRAME: if (frame_done) state <= S_HALT;
        S_HALT: if (cpu_halted) begin
          state   <= S_SAVE;
          idx     <= '0;
          sub     <= 1'b0;
          src_sum <= '0;
        end
        S_SAVE: begin
          if (!sub && mem_done) begin
            hold    <= mem_rdata;
            src_sum <= src_sum + 32'(mem_rdata);
            sub     <= 1'b1;
          end else if (sub && st_done) begin
            sub <= 1'b0;
            if (last) begin
              state   <= S_VERIFY;
              ld      <= 1'b0;
              idx     <= '0;
              dst_sum <= '0;
              mis     <= 1'b0;
            end else idx <= idx + 1'b1;
          end
        end
        S_CLEAR: if (mem_done) begin
          if (last) begin
            state   <= S_LOAD;
            idx     <= '0;
            sub     <= 1'b0;
            src_sum <= '0;
          end else idx <= idx + 1'b1;
        end
        S_LOAD: begin
          if (!sub && st_done) begin
            hold    <= st_rdata;
            src_sum <= src_sum + 32'(st_rdata);
            sub     <= 1'b1;
          end else if (sub && mem_done) begin
            sub <= 1'b0;
            if (last) begin
              state   <= S_VERIFY;
              ld      <= 1'b1;
              idx     <= '0;
              dst_sum <= '0;
              mis     <= 1'b0;
            end else idx <= idx + 1'b1;
          end
        end
        S_VERIFY: if (vdone) begin
          if (!sub) begin
            dst_sum <= fin_dst;
            hold    <= drd;
          end
          mis <= fin_mis;
          if (word_end) begin
            sub <= 1'b0;
            if (last) begin
              idx   <= '0;
              state <= !pass ? S_ERROR : (ld ? S_RESUME : S_CLEAR);
            end else idx <= idx + 1'b1;
          end else sub <= 1'b1;
        end
        S_RESUME: begin
          cur   <= tgt;
          state <= S_IDLE;
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/game_swap_seq_chk.sv
module game_swap_seq_chk #(
  parameter int AW = 4,
  parameter int GW = 2,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic          cpu_halted,
  input logic          busy,
  input logic          cpu_halt,
  input logic          sw_error,
  input logic [GW-1:0] cur_game,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          st_req,
  input logic          st_we,
  input logic [GW+AW-1:0] st_addr,
  input logic [DW-1:0] st_wdata,
  input logic          st_ready
);

  AST_HALT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(frame_done)); // R3

  AST_NO_ACCESS_UNHALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || st_req) |-> (cpu_halted && busy)); // R4

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_error |=> (sw_error && cpu_halt && busy && !mem_req && !st_req)); // R8

  AST_GAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> $stable(cur_game)); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ready) |=> (st_req && $stable(st_addr) && $stable(st_we) && $stable(st_wdata))); // R11

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && st_req)); // R11

endmodule

bind game_swap_seq game_swap_seq_chk #(.AW(AW), .GW(GW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cpu_halted(cpu_halted),
  .busy(busy), .cpu_halt(cpu_halt), .sw_error(sw_error), .cur_game(cur_game),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .st_req(st_req), .st_we(st_we), .st_addr(st_addr),
  .st_wdata(st_wdata), .st_ready(st_ready)
);

// File: tb/sim_game_swap_seq.sv
module sim_game_swap_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, WORDS = 16, GAMES = 4, AW = 4, GW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, frame_done = 0;
  logic [GW-1:0] req_game = '0;
  logic cpu_halted;
  logic busy, cpu_halt, sw_error;
  logic [GW-1:0] cur_game;
  logic mem_req, mem_we, mem_ready, st_req, st_we, st_ready;
  logic [AW-1:0] mem_addr;
  logic [GW+AW-1:0] st_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, st_wdata, st_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  game_swap_seq #(.DW(DW), .WORDS(WORDS), .GAMES(GAMES), .INIT_GAME(0), .ECHO(1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_game(req_game),
    .frame_done(frame_done), .cpu_halted(cpu_halted), .busy(busy), .cpu_halt(cpu_halt),
    .sw_error(sw_error), .cur_game(cur_game), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .st_req(st_req), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
    .st_ready(st_ready), .st_rdata(st_rdata));

  // memory, storage and CPU models
  logic [DW-1:0] mem_m [WORDS];
  logic [DW-1:0] store_m [GAMES][WORDS];
  logic [3:0] halt_sr = '0;
  logic [7:0] lfsr = 8'h5a;
  bit stall_en = 0;
  int corrupt = 0;
  int acc_cnt = 0, zcnt = 0;
  bit order_bad = 0, unhalted_acc = 0;

  assign cpu_halted = cpu_halt && halt_sr[3];
  assign mem_ready  = !stall_en || lfsr[0] || lfsr[5];
  assign st_ready   = !stall_en || lfsr[2] || lfsr[6];
  assign mem_rdata  = mem_m[mem_addr];
  assign st_rdata   = store_m[st_addr[GW+AW-1:AW]][st_addr[AW-1:0]];

  always @(posedge clk) begin
    logic [DW-1:0] d;
    halt_sr <= {halt_sr[2:0], cpu_halt};
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n && (mem_req || st_req)) begin
      acc_cnt <= acc_cnt + 1;
      if (!cpu_halted) unhalted_acc <= 1;
    end
    if (rst_n && st_req && st_we && st_ready) begin
      d = st_wdata;
      if (corrupt == 1 && st_addr[AW-1:0] == 3) d = d + 1;
      if (corrupt == 2 && st_addr[AW-1:0] == 2) d = d + 1;
      if (corrupt == 2 && st_addr[AW-1:0] == 3) d = d - 1;
      store_m[st_addr[GW+AW-1:AW]][st_addr[AW-1:0]] <= d;
    end
    if (rst_n && mem_req && mem_we && mem_ready) begin
      d = mem_wdata;
      if (d == 0) zcnt <= zcnt + 1;
      else if (zcnt < WORDS) order_bad <= 1;
      if (corrupt == 3 && d != 0 && mem_addr == 5) d = d ^ 16'h0100;
      mem_m[mem_addr] <= d;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, string what, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit ok; int game; string tag; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] exp_mem [WORDS];
  logic [DW-1:0] exp_saved [WORDS];
  int old_game = 0, bench_game = 0, done_cnt = 0;

  initial begin
    exp_t it;
    forever begin
      wait (exp_q.size() > 0);
      it = exp_q[0];
      @(negedge clk);
      while (busy && !sw_error) @(negedge clk);
      if (it.ok) begin
        int bad_m, bad_s;
        bad_m = 0; bad_s = 0;
        for (int i = 0; i < WORDS; i++) begin
          if (mem_m[i] !== exp_mem[i]) bad_m++;
          if (store_m[old_game][i] !== exp_saved[i]) bad_s++;
        end
        chk(sw_error == 0, "R8", "no error on clean switch", sw_error, 0);
        chk(cur_game == it.game, "R7", "cur_game after switch", cur_game, it.game);
        chk(cpu_halt == 0 && busy == 0, "R7", "released and idle", {cpu_halt, busy}, 0);
        chk(bad_m == 0, "R7", "loaded words wrong", bad_m, 0);
        chk(bad_s == 0, "R5", "saved words wrong", bad_s, 0);
        chk(zcnt == WORDS && !order_bad, "R6", "zero fill count/order", zcnt, WORDS);
        bench_game = it.game;
      end else begin
        chk(sw_error == 1, it.tag, "error raised", sw_error, 1);
        chk(cpu_halt == 1 && busy == 1, it.tag, "halt and busy held", {cpu_halt, busy}, 3);
      end
      chk(!unhalted_acc, "R4", "access before cpu_halted", unhalted_acc, 0);
      void'(exp_q.pop_front());
      done_cnt++;
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    bench_game = 0;
    @(negedge clk);
    chk(busy == 0 && cpu_halt == 0 && sw_error == 0, "R1", "outputs after reset",
        {busy, cpu_halt, sw_error}, 0);
    chk(cur_game == 0, "R1", "cur_game after reset", cur_game, 0);
    chk(!mem_req && !st_req, "R1", "ports quiet after reset", {mem_req, st_req}, 0);
  endtask

  task automatic do_switch(int g, int mode, bit ok, string tag, bit extra);
    int k;
    exp_t it;
    old_game = bench_game;
    for (int i = 0; i < WORDS; i++) begin
      exp_saved[i] = mem_m[i];
      exp_mem[i] = (g == bench_game) ? mem_m[i] : store_m[g][i];
    end
    zcnt = 0; order_bad = 0; unhalted_acc = 0; acc_cnt = 0;
    corrupt = mode;
    k = done_cnt;
    @(negedge clk);
    req_valid = 1; req_game = GW'(g);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R2", "busy after accept", busy, 1);
    it.ok = ok; it.game = g; it.tag = tag;
    exp_q.push_back(it);
    if (extra) begin
      req_valid = 1; req_game = GW'(g ^ 1);
      @(negedge clk);
      req_valid = 0;
    end
    repeat (10) @(negedge clk);
    chk(cpu_halt == 0, "R3", "halt before frame end", cpu_halt, 0);
    chk(acc_cnt == 0, "R3", "no traffic before frame end", acc_cnt, 0);
    frame_done = 1;
    @(negedge clk);
    frame_done = 0;
    chk(cpu_halt == 1, "R3", "halt cycle after frame end", cpu_halt, 1);
    if (extra) begin
      repeat (12) @(negedge clk);
      req_valid = 1; req_game = GW'(g ^ 2);
      @(negedge clk);
      req_valid = 0;
      chk(busy == 1, "R10", "busy through mid-switch request", busy, 1);
    end
    wait (done_cnt == k + 1);
    corrupt = 0;
  endtask

  task automatic after_error(string tag);
    int a;
    a = acc_cnt;
    @(negedge clk);
    req_valid = 1; req_game = 2'd1;
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    chk(sw_error == 1 && cpu_halt == 1, tag, "error sticky after request", {sw_error, cpu_halt}, 3);
    chk(acc_cnt == a, "R8", "no traffic in error", acc_cnt, a);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem_m[i] = DW'(16'h1000 + i * 3 + 1);
      for (int g = 0; g < GAMES; g++) store_m[g][i] = DW'(g * 256 + i * 7 + 5);
    end
    do_reset();
    do_switch(2, 0, 1, "R7", 1);           // R10 stray requests ignored
    stall_en = 1;
    do_switch(1, 0, 1, "R11", 0);          // R11 under random stalls
    stall_en = 0;
    do_switch(1, 0, 1, "R7", 0);           // R7 same game
    do_switch(2, 1, 0, "R8", 0);           // R8 save sum mismatch
    after_error("R8");
    do_reset();
    do_switch(3, 2, 0, "R9", 0);           // R9 equal sums, word mismatch
    after_error("R9");
    do_reset();
    stall_en = 1;
    do_switch(2, 3, 0, "R8", 0);           // R8 load sum mismatch
    stall_en = 0;
    do_reset();
    do_switch(3, 0, 1, "R7", 0);           // recovery after reset
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule